// File: doc/BRIEF.md
# Receive-Side Software Flow Controller

This block sits beside a serial receiver and its transmitter. It watches every received byte for a programmed stop pattern and a programmed go pattern. A pattern is either one character or two characters received one after the other. When the stop pattern arrives, a status flag is raised and the local transmitter is paused. The pause takes effect only at a character boundary, so the transmitter always finishes the character it is sending. When the go pattern arrives, the flag clears and the pause is lifted.

The block also manages the other direction of flow control. It compares the receive FIFO fill level against a high mark and a low mark. When the level rises to the high mark, it asks the transmitter to insert the stop pattern into the outgoing stream. When the level later falls to the low mark, it asks for the go pattern. Each request is made once per threshold crossing. The block never removes bytes from the receive stream: the characters it matches still go to the receive FIFO through the normal path.

Top module: `sw_flow_ctrl`

## Requirements
- R1: After reset, txPause, matchFlag, irq and sendReq are all low.
- R2: With flowEn high and pairMode low, a received byte equal to stopChar1 halts transmission. If txActive is low, txPause is high after that same clock edge.
- R3: While txActive is high and txCharDone is low, a pending halt does not raise txPause. txPause rises at the first edge where txCharDone is sampled high.
- R4: A stop match sets matchFlag at the edge that samples the byte. irq is high exactly when matchFlag and irqEn are both high.
- R5: A go match while halted clears txPause and matchFlag at the edge that samples the byte. A go byte received while not halted changes nothing.
- R6: With pairMode high, a stop match needs stopChar1 followed by stopChar2 in consecutive received bytes. Either character alone does nothing.
- R7: In pair mode, a second byte that does not complete the pattern abandons the partial match. That byte is then judged as a possible first character, so the sequence stopChar1, stopChar1, stopChar2 matches, while stopChar1, other, stopChar2 does not.
- R8: When rxLevel >= hiMark and no stop has been requested since the last go, sendReq rises with sendChar = stopChar1, followed by stopChar2 in pair mode. It is raised once per crossing, even if the level stays high.
- R9: After a stop was requested, rxLevel <= loMark raises sendReq with sendChar = goChar1, followed by goChar2 in pair mode. This happens once per crossing.
- R10: sendReq and sendChar hold until sendAck is sampled high, and sendReq is raised regardless of txPause.
- R11: While flowEn is low, txPause, matchFlag and sendReq are forced low, and received bytes and fill levels are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| flowEn | input | 1 | Enables software flow control |
| pairMode | input | 1 | 0: one-character patterns, 1: two-character patterns |
| irqEn | input | 1 | Receive interrupt enable |
| rxValid | input | 1 | One-cycle strobe marking a received byte |
| rxData | input | CHAR_W | Received byte |
| stopChar1 | input | CHAR_W | First stop character |
| stopChar2 | input | CHAR_W | Second stop character (pair mode) |
| goChar1 | input | CHAR_W | First go character |
| goChar2 | input | CHAR_W | Second go character (pair mode) |
| rxLevel | input | LVL_W | Receive FIFO fill level |
| hiMark | input | LVL_W | Level at which a stop is requested (1..128) |
| loMark | input | LVL_W | Level at which a go is requested (below hiMark) |
| txActive | input | 1 | Transmitter is shifting a character |
| txCharDone | input | 1 | Transmitter finished a character this cycle |
| sendAck | input | 1 | Transmitter took the inserted character |
| txPause | output | 1 | Holds the transmitter at a character boundary |
| matchFlag | output | 1 | A stop pattern was matched and no go has followed |
| irq | output | 1 | Interrupt output |
| sendReq | output | 1 | Request to insert a flow-control character ahead of data |
| sendChar | output | CHAR_W | Character to insert |

## Verification
The partial-match register is the one piece of state the ports cannot show directly. If it is wrong, the fault appears on txPause and matchFlag at the edge that samples the completing byte, or as a pause that arrives one byte too early. The bench drives the mismatch, restart and lone-character sequences that expose this.

A wrong crossing memory shows up differently. It causes a repeated or missing insertion request a cycle after rxLevel moves, and the scoreboard catches it as an unexpected or missing character. A halt state that is out of step with the pause output shows up as txPause changing while txActive is high without txCharDone.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic watchGo;    // go matcher armed only while halted
    logic flush;      // drop partial matches
    logic selGo;      // insertion pattern: 0 stop, 1 go
    logic selSecond;  // insertion character index
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic stopHit;
    logic goHit;
    logic levelHigh;
    logic levelLow;
  } dpStat_t;

  typedef enum logic [1:0] {
    SEND_IDLE  = 2'd0,
    SEND_FIRST = 2'd1,
    SEND_NEXT  = 2'd2
  } sendState_t;
endpackage

// File: rtl/sfc_seq_match.sv
module sfc_seq_match #(
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic              enable,
  input  logic              pairMode,
  input  logic              byteValid,
  input  logic [CHAR_W-1:0] byteData,
  input  logic [CHAR_W-1:0] firstChar,
  input  logic [CHAR_W-1:0] secondChar,
  output logic              hit
);
  logic armed;
  logic isFirst;
  logic isSecond;

  assign isFirst  = (byteData == firstChar);
  assign isSecond = (byteData == secondChar);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (clear || !enable || !pairMode) begin
      armed <= 1'b0;
    end else if (byteValid) begin
      // a completed pair disarms; otherwise this byte may start a new pair
      armed <= isFirst && !(armed && isSecond);
    end
  end

  assign hit = byteValid && enable && !clear &&
               (pairMode ? (armed && isSecond) : isFirst);
endmodule

// File: rtl/sfc_datapath.sv
module sfc_datapath
  import sfc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pairMode,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic [CHAR_W-1:0] stopChar1,
  input  logic [CHAR_W-1:0] stopChar2,
  input  logic [CHAR_W-1:0] goChar1,
  input  logic [CHAR_W-1:0] goChar2,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  hiMark,
  input  logic [LVL_W-1:0]  loMark,
  input  dpCtrl_t           ctrl,
  output dpStat_t           stat,
  output logic [CHAR_W-1:0] sendChar
);
  localparam int NUM_PAT = 2;  // index 0 stop, 1 go

  logic [CHAR_W-1:0] patFirst  [NUM_PAT];
  logic [CHAR_W-1:0] patSecond [NUM_PAT];
  logic [NUM_PAT-1:0] patEnable;
  logic [NUM_PAT-1:0] patHit;

  assign patFirst[0]  = stopChar1;
  assign patSecond[0] = stopChar2;
  assign patFirst[1]  = goChar1;
  assign patSecond[1] = goChar2;
  assign patEnable    = {ctrl.watchGo, 1'b1};

  for (genvar g = 0; g < NUM_PAT; g++) begin : gMatch
    sfc_seq_match #(.CHAR_W(CHAR_W)) uMatch (
      .clk       (clk),
      .rstN      (rstN),
      .clear     (ctrl.flush),
      .enable    (patEnable[g]),
      .pairMode  (pairMode),
      .byteValid (rxValid),
      .byteData  (rxData),
      .firstChar (patFirst[g]),
      .secondChar(patSecond[g]),
      .hit       (patHit[g])
    );
  end

  always_comb begin
    stat.stopHit   = patHit[0];
    stat.goHit     = patHit[1];
    stat.levelHigh = (rxLevel >= hiMark);
    stat.levelLow  = (rxLevel <= loMark);
  end

  always_comb begin
    if (ctrl.selSecond) sendChar = patSecond[ctrl.selGo];
    else                sendChar = patFirst[ctrl.selGo];
  end
endmodule

// File: rtl/sfc_control.sv
module sfc_control
  import sfc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    flowEn,
  input  logic    pairMode,
  input  logic    irqEn,
  input  logic    txActive,
  input  logic    txCharDone,
  input  logic    sendAck,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    txPause,
  output logic    matchFlag,
  output logic    irq,
  output logic    sendReq
);
  sendState_t state;
  logic       selGo;
  logic       stopSent;
  logic       haltNext;
  logic       atBoundary;

  assign haltNext   = (matchFlag || stat.stopHit) && !stat.goHit;
  assign atBoundary = txPause || !txActive || txCharDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchFlag <= 1'b0;
      txPause   <= 1'b0;
    end else if (!flowEn) begin
      matchFlag <= 1'b0;
      txPause   <= 1'b0;
    end else begin
      matchFlag <= haltNext;
      txPause   <= haltNext && atBoundary;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEND_IDLE;
      selGo    <= 1'b0;
      stopSent <= 1'b0;
    end else if (!flowEn) begin
      state    <= SEND_IDLE;
      selGo    <= 1'b0;
      stopSent <= 1'b0;
    end else begin
      unique case (state)
        SEND_IDLE: begin
          if (!stopSent && stat.levelHigh) begin
            state    <= SEND_FIRST;
            selGo    <= 1'b0;
            stopSent <= 1'b1;
          end else if (stopSent && stat.levelLow) begin
            state    <= SEND_FIRST;
            selGo    <= 1'b1;
            stopSent <= 1'b0;
          end
        end
        SEND_FIRST: if (sendAck) state <= pairMode ? SEND_NEXT : SEND_IDLE;
        SEND_NEXT:  if (sendAck) state <= SEND_IDLE;
        default:    state <= SEND_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.watchGo   = matchFlag;
    ctrl.flush     = !flowEn;
    ctrl.selGo     = selGo;
    ctrl.selSecond = (state == SEND_NEXT);
  end

  assign sendReq = (state != SEND_IDLE);
  assign irq     = matchFlag && irqEn;
endmodule

// File: rtl/sw_flow_ctrl.sv
module sw_flow_ctrl
  import sfc_pkg::*;
#(
  parameter int CHAR_W = 8,
  parameter int LVL_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              flowEn,
  input  logic              pairMode,
  input  logic              irqEn,
  input  logic              rxValid,
  input  logic [CHAR_W-1:0] rxData,
  input  logic [CHAR_W-1:0] stopChar1,
  input  logic [CHAR_W-1:0] stopChar2,
  input  logic [CHAR_W-1:0] goChar1,
  input  logic [CHAR_W-1:0] goChar2,
  input  logic [LVL_W-1:0]  rxLevel,
  input  logic [LVL_W-1:0]  hiMark,
  input  logic [LVL_W-1:0]  loMark,
  input  logic              txActive,
  input  logic              txCharDone,
  input  logic              sendAck,
  output logic              txPause,
  output logic              matchFlag,
  output logic              irq,
  output logic              sendReq,
  output logic [CHAR_W-1:0] sendChar
);
  dpCtrl_t ctrl;
  dpStat_t stat;

  sfc_datapath #(.CHAR_W(CHAR_W), .LVL_W(LVL_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .pairMode (pairMode),
    .rxValid  (rxValid),
    .rxData   (rxData),
    .stopChar1(stopChar1),
    .stopChar2(stopChar2),
    .goChar1  (goChar1),
    .goChar2  (goChar2),
    .rxLevel  (rxLevel),
    .hiMark   (hiMark),
    .loMark   (loMark),
    .ctrl     (ctrl),
    .stat     (stat),
    .sendChar (sendChar)
  );

  sfc_control uCtl (
    .clk       (clk),
    .rstN      (rstN),
    .flowEn    (flowEn),
    .pairMode  (pairMode),
    .irqEn     (irqEn),
    .txActive  (txActive),
    .txCharDone(txCharDone),
    .sendAck   (sendAck),
    .stat      (stat),
    .ctrl      (ctrl),
    .txPause   (txPause),
    .matchFlag (matchFlag),
    .irq       (irq),
    .sendReq   (sendReq)
  );
endmodule

// File: rtl/sw_flow_ctrl_chk.sv
module sw_flow_ctrl_chk (
  input logic clk,
  input logic rstN,
  input logic flowEn,
  input logic rxValid,
  input logic txActive,
  input logic txCharDone,
  input logic sendAck,
  input logic txPause,
  input logic matchFlag,
  input logic sendReq
);
  // R3
  pause_at_boundary_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txPause) |-> $past(!txActive || txCharDone));

  // R4
  flag_from_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(matchFlag) |-> $past(rxValid));

  // R5
  pause_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    txPause |-> matchFlag);

  // R10
  req_held_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sendReq && !sendAck && flowEn) |=> sendReq);

  // R11
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !flowEn |=> (!txPause && !matchFlag && !sendReq));

  // R8
  req_needs_enable_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sendReq) |-> $past(flowEn));
endmodule

bind sw_flow_ctrl sw_flow_ctrl_chk uChk (
  .clk       (clk),
  .rstN      (rstN),
  .flowEn    (flowEn),
  .rxValid   (rxValid),
  .txActive  (txActive),
  .txCharDone(txCharDone),
  .sendAck   (sendAck),
  .txPause   (txPause),
  .matchFlag (matchFlag),
  .sendReq   (sendReq)
);

// File: tb/sw_flow_ctrl_test.sv
module sw_flow_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] STOP1 = 8'h13, STOP2 = 8'h93;
  localparam logic [7:0] GO1 = 8'h11, GO2 = 8'h91;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic flowEn = 1'b0, pairMode = 1'b0, irqEn = 1'b0;
  logic rxValid = 1'b0;
  logic [7:0] rxData = '0;
  logic [7:0] rxLevel = '0;
  logic txActive = 1'b0, txCharDone = 1'b0, sendAck = 1'b0;
  logic txPause, matchFlag, irq, sendReq;
  logic [7:0] sendChar;

  int checks = 0;
  int fails = 0;
  bit monEn = 1'b0;
  logic [7:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_flow_ctrl uut (
    .clk(clk), .rstN(rstN), .flowEn(flowEn), .pairMode(pairMode), .irqEn(irqEn),
    .rxValid(rxValid), .rxData(rxData),
    .stopChar1(STOP1), .stopChar2(STOP2), .goChar1(GO1), .goChar2(GO2),
    .rxLevel(rxLevel), .hiMark(8'd8), .loMark(8'd2),
    .txActive(txActive), .txCharDone(txCharDone), .sendAck(sendAck),
    .txPause(txPause), .matchFlag(matchFlag), .irq(irq),
    .sendReq(sendReq), .sendChar(sendChar)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sendByte(logic [7:0] b);
    rxValid = 1'b1;
    rxData  = b;
    @(negedge clk);
    rxValid = 1'b0;
  endtask

  // scoreboard monitor: acknowledges insertion requests and compares
  always @(negedge clk) begin
    if (sendAck) begin
      sendAck = 1'b0;
    end else if (monEn && rstN && sendReq) begin
      checks++;
      if (expQ.size() == 0) begin
        fails++;
        $display("FAIL R8/R9 unexpected insertion got %0h exp none", sendChar);
      end else begin
        logic [7:0] e;
        e = expQ.pop_front();
        if (sendChar !== e) begin
          fails++;
          $display("FAIL R8/R9 insertion char got %0h exp %0h", sendChar, e);
        end
      end
      sendAck = 1'b1;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    checks++;
    $display("FAIL watchdog got timeout exp finish");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    idle(3);
    check("R1 txPause", txPause, 0);
    check("R1 matchFlag", matchFlag, 0);
    check("R1 irq", irq, 0);
    check("R1 sendReq", sendReq, 0);
    rstN = 1'b1;
    flowEn = 1'b1;
    irqEn = 1'b1;
    idle(2);

    // single-character mode
    sendByte(8'h41);
    check("R2 other byte no pause", txPause, 0);
    sendByte(GO1);
    check("R5 go while running no flag", matchFlag, 0);
    sendByte(STOP1);
    check("R2 stop pauses", txPause, 1);
    check("R4 flag set", matchFlag, 1);
    check("R4 irq with enable", irq, 1);
    irqEn = 1'b0;
    #1;
    check("R4 irq masked", irq, 0);
    irqEn = 1'b1;
    sendByte(GO1);
    check("R5 go clears pause", txPause, 0);
    check("R5 go clears flag", matchFlag, 0);

    // character boundary
    txActive = 1'b1;
    sendByte(STOP1);
    check("R3 flag during char", matchFlag, 1);
    check("R3 no pause mid char", txPause, 0);
    idle(3);
    check("R3 still no pause", txPause, 0);
    txCharDone = 1'b1;
    @(negedge clk);
    txCharDone = 1'b0;
    check("R3 pause at boundary", txPause, 1);
    txActive = 1'b0;
    sendByte(GO1);
    check("R5 resume", txPause, 0);

    // pair mode
    pairMode = 1'b1;
    idle(1);
    sendByte(STOP2);
    check("R6 lone second no match", matchFlag, 0);
    sendByte(STOP1);
    check("R6 lone first no match", matchFlag, 0);
    sendByte(8'h41);
    sendByte(STOP2);
    check("R7 broken pair no match", matchFlag, 0);
    sendByte(STOP1);
    idle(2);
    sendByte(STOP1);
    sendByte(STOP2);
    check("R7 restart pair matches", txPause, 1);
    sendByte(GO1);
    check("R6 go half no resume", txPause, 1);
    sendByte(GO2);
    check("R6 go pair resumes", txPause, 0);

    // threshold insertions, single
    pairMode = 1'b0;
    monEn = 1'b1;
    expQ.push_back(STOP1);
    rxLevel = 8'd8;
    idle(6);
    rxLevel = 8'd10;
    idle(6);
    rxLevel = 8'd5;
    idle(4);
    check("R8 once per crossing", expQ.size(), 0);
    expQ.push_back(GO1);
    rxLevel = 8'd2;
    idle(6);
    check("R9 go inserted", expQ.size(), 0);
    rxLevel = 8'd0;
    idle(4);

    // threshold insertions, pair
    pairMode = 1'b1;
    expQ.push_back(STOP1);
    expQ.push_back(STOP2);
    rxLevel = 8'd9;
    idle(8);
    check("R8 pair stop inserted", expQ.size(), 0);
    expQ.push_back(GO1);
    expQ.push_back(GO2);
    rxLevel = 8'd1;
    idle(8);
    check("R9 pair go inserted", expQ.size(), 0);

    // request held without ack, also while paused
    pairMode = 1'b0;
    monEn = 1'b0;
    sendByte(STOP1);
    check("R10 paused", txPause, 1);
    rxLevel = 8'd8;
    idle(5);
    check("R10 req while paused", sendReq, 1);
    check("R10 char held", sendChar, STOP1);
    expQ.push_back(STOP1);
    monEn = 1'b1;
    idle(4);
    check("R10 taken after ack", expQ.size(), 0);

    // disable
    flowEn = 1'b0;
    idle(2);
    check("R11 pause cleared", txPause, 0);
    check("R11 flag cleared", matchFlag, 0);
    check("R11 no req", sendReq, 0);
    sendByte(STOP1);
    check("R11 byte ignored", matchFlag, 0);
    rxLevel = 8'd0;
    idle(1);
    flowEn = 1'b1;
    idle(4);
    check("R11 no stale go", sendReq, 0);
    check("R8 queue drained", expQ.size(), 0);

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule